// File: doc/BRIEF.md
# Floppy Controller Command and Interrupt Engine

This block is the host-facing register side of a floppy disk controller. The host writes a control register that can hold the controller in reset. It polls a status register that tells it whether the data port expects a command byte or holds a result byte. It moves commands and results through one byte-wide data port. The engine runs the positioning and housekeeping commands: seek, recalibrate, sense interrupt, specify, and a catch-all for unrecognised codes. Commands that would move sector data are treated as unrecognised. No media, stepping timer or DMA engine sits behind it.

Each of the four drives keeps a present-cylinder register, a status-0 byte and an interrupt-pending flag. One interrupt request line is raised whenever a drive finishes a positioning command. Leaving the held-reset state marks every drive as having become not ready. Software then drains these events one drive at a time with sense-interrupt commands. The line falls only when the last pending drive has been reported.

The host bus is synchronous. A write is one cycle with `wr_en` high. A read is one cycle with `rd_en` high, and `rd_data` holds the answer from the following clock edge. `reg_sel` picks the register: 0 is the control register (write), 1 is the main status (read), 2 is the data port (read and write).

Top module: `fdc_cmd_engine`

## Requirements
- R1: After the synchronous reset the engine is held in controller reset. `irq` is low, a status read gives 0x80, a data-port read gives 0x80 and `spec_params` is zero.
- R2: While bit 2 of the last control-register write is 0, `irq` stays low and data-port writes are ignored.
- R3: A control write that sets bit 2 while the engine is held resets the controller. Any partly received command and any unread results are discarded. All four drives get a pending interrupt with status-0 0xC0, and `irq` goes high. Cylinder registers keep their values.
- R4: Seek takes 3 bytes: code 0x0F, a select byte (bits 1..0 drive, bit 2 head), and the target cylinder. It loads that drive's cylinder, sets its status-0 to (select byte & 0x07) | 0x20, marks it pending and raises `irq`.
- R5: Recalibrate takes 2 bytes: code 0x07 and a select byte. It sets that drive's cylinder to 0, sets status-0 to the drive number | 0x20, marks it pending and raises `irq`.
- R6: Sense interrupt is the 1-byte code 0x08. It reports the lowest-numbered pending drive: first its status-0, then its cylinder. It clears that drive's flag. `irq` falls only when no drive is left pending. With no drive pending, it returns the single byte 0x80 and `irq` is unchanged.
- R7: Main status reads 0xD0 while result bytes remain unread (bit 7 ready, bit 6 direction to host, bit 4 busy). Otherwise it reads 0x80.
- R8: Result bytes are read from the data port in the order they were produced. A data read with no result left returns 0x80.
- R9: The command code is the low 5 bits of the first byte; the upper 3 bits are ignored. Any code other than 0x03, 0x07, 0x08 or 0x0F is a 1-byte command that returns the single result 0x80.
- R10: Specify takes 3 bytes: code 0x03 and two parameters. It presents them on `spec_params` as {first, second} and produces no result bytes.
- R11: Data-port writes made while result bytes are unread are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle host write strobe |
| rd_en | input | 1 | One-cycle host read strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 main status, 2 data port |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Read byte, valid from the edge after `rd_en` |
| irq | output | 1 | Interrupt request |
| spec_params | output | 16 | Parameters from the last specify command |

## Verification
The bench targets the interrupt drain order. Four pending drives must be reported lowest first, and `irq` must stay high until the final one. A design that dropped the line after the first sense, or picked the wrong drive, gives the wrong status-0 or line level. A stray byte written while results are unread is followed by a recalibrate. If that byte were accepted, the recalibrate bytes would be taken as seek parameters and the reported status-0 would read 0x27 instead of 0x21. A seek left half-received when the controller reset is followed by a sense code. A design that failed to flush would swallow that code as a seek operand and return no result. The bench also checks that a high-bit-decorated seek code still seeks, that cylinder values survive a controller reset, and that unread results vanish on one.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  localparam int BYTE_W = 8;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam int         CTRL_RUN_BIT = 2;

  localparam logic [4:0] OP_SPECIFY = 5'h03;
  localparam logic [4:0] OP_RECAL   = 5'h07;
  localparam logic [4:0] OP_SENSE   = 5'h08;
  localparam logic [4:0] OP_SEEK    = 5'h0F;

  localparam logic [BYTE_W-1:0] ST0_NOT_READY = 8'hC0;
  localparam logic [BYTE_W-1:0] ST0_SEEK_END  = 8'h20;
  localparam logic [BYTE_W-1:0] RES_INVALID   = 8'h80;
  localparam logic [BYTE_W-1:0] MSR_READY     = 8'h80;
  localparam logic [BYTE_W-1:0] MSR_TO_HOST   = 8'h40;
  localparam logic [BYTE_W-1:0] MSR_BUSY      = 8'h10;

  // Total byte count of a command, selected by its code.
  function automatic logic [1:0] cmd_len(input logic [4:0] code);
    case (code)
      OP_SEEK, OP_SPECIFY: cmd_len = 2'd3;
      OP_RECAL:            cmd_len = 2'd2;
      default:             cmd_len = 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/fdc_cmd_collect.sv
module fdc_cmd_collect
  import fdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              byte_en,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              cmd_valid,
  output logic [4:0]        cmd_code,
  output logic [BYTE_W-1:0] arg1,
  output logic [BYTE_W-1:0] arg2
);
  logic [1:0]        cnt_q, need_q;
  logic [4:0]        code_q;
  logic [BYTE_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt_q     <= '0;
      need_q    <= '0;
      code_q    <= '0;
      hold_q    <= '0;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      arg1      <= '0;
      arg2      <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (byte_en) begin
        if (cnt_q == 2'd0) begin
          if (cmd_len(byte_in[4:0]) == 2'd1) begin
            cmd_valid <= 1'b1;
            cmd_code  <= byte_in[4:0];
            arg1      <= '0;
            arg2      <= '0;
          end else begin
            code_q <= byte_in[4:0];
            need_q <= cmd_len(byte_in[4:0]);
            cnt_q  <= 2'd1;
          end
        end else if (cnt_q + 2'd1 == need_q) begin
          cmd_valid <= 1'b1;
          cmd_code  <= code_q;
          arg1      <= (cnt_q == 2'd1) ? byte_in : hold_q;
          arg2      <= (cnt_q == 2'd2) ? byte_in : '0;
          cnt_q     <= 2'd0;
        end else begin
          hold_q <= byte_in;
          cnt_q  <= cnt_q + 2'd1;
        end
      end
    end
  end

  // R9: the top accepts no byte while a command is being executed
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  // R3: a controller reset discards any partly received command
  a_r3_flush_idle: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt_q == 2'd0 && !cmd_valid));
endmodule

// File: rtl/fdc_result_queue.sv
module fdc_result_queue
  import fdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push_two,
  input  logic              push_one,
  input  logic [BYTE_W-1:0] in0,
  input  logic [BYTE_W-1:0] in1,
  input  logic              pop,
  output logic [BYTE_W-1:0] head,
  output logic              avail
);
  logic [BYTE_W-1:0] q0, q1;
  logic [1:0]        cnt_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt_q <= '0;
      q0    <= '0;
      q1    <= '0;
    end else if (push_two) begin
      q0    <= in0;
      q1    <= in1;
      cnt_q <= 2'd2;
    end else if (push_one) begin
      q0    <= in0;
      cnt_q <= 2'd1;
    end else if (pop && cnt_q != 2'd0) begin
      q0    <= q1;
      cnt_q <= cnt_q - 2'd1;
    end
  end

  assign head  = q0;
  assign avail = (cnt_q != 2'd0);

  // R11: results are only produced into an empty queue
  a_r11_push_empty: assert property (@(posedge clk) disable iff (rst)
    (push_two || push_one) |-> (cnt_q == 2'd0));
  // R8: the first byte produced is the first byte offered
  a_r8_order: assert property (@(posedge clk) disable iff (rst)
    push_two |=> (head == $past(in0)));
endmodule

// File: rtl/fdc_drive_slot.sv
module fdc_drive_slot
  import fdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mark_all,
  input  logic              load,
  input  logic              clear,
  input  logic [BYTE_W-1:0] cyl_in,
  input  logic [BYTE_W-1:0] st0_in,
  output logic [BYTE_W-1:0] track,
  output logic [BYTE_W-1:0] st0,
  output logic              pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      track <= '0;
      st0   <= '0;
      pend  <= 1'b0;
    end else if (mark_all) begin
      st0  <= ST0_NOT_READY;
      pend <= 1'b1;
    end else if (load) begin
      track <= cyl_in;
      st0   <= st0_in;
      pend  <= 1'b1;
    end else if (clear) begin
      pend <= 1'b0;
    end
  end

  // R3: leaving held reset marks the drive not ready and pending
  a_r3_all_pending: assert property (@(posedge clk) disable iff (rst)
    mark_all |=> (pend && st0 == ST0_NOT_READY));
  // R6: a reported drive no longer pends
  a_r6_cleared: assert property (@(posedge clk) disable iff (rst)
    (clear && !mark_all && !load) |=> !pend);
endmodule

// File: rtl/fdc_cmd_engine.sv
module fdc_cmd_engine
  import fdc_pkg::*;
#(
  parameter int NUM_DRIVES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [1:0]          reg_sel,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic [BYTE_W-1:0]   rd_data,
  output logic                irq,
  output logic [2*BYTE_W-1:0] spec_params
);
  localparam int DRV_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1;

  logic hold_q, irq_q;
  logic [BYTE_W-1:0]   rd_q;
  logic [2*BYTE_W-1:0] spec_q;

  logic              cmd_valid;
  logic [4:0]        cmd_code;
  logic [BYTE_W-1:0] arg1, arg2;
  logic [BYTE_W-1:0] res_head;
  logic              res_avail;

  logic [NUM_DRIVES-1:0][BYTE_W-1:0] track_v, st0_v;
  logic [NUM_DRIVES-1:0]             pend_v, remaining;
  logic              sense_hit;
  logic [DRV_W-1:0]  sense_idx;

  // host bus decode
  logic dor_wr, reset_edge, data_wr, data_rd;
  assign dor_wr     = wr_en && reg_sel == SEL_CTRL;
  assign reset_edge = dor_wr && wr_data[CTRL_RUN_BIT] && hold_q;
  assign data_wr    = wr_en && reg_sel == SEL_DATA && !hold_q && !res_avail && !cmd_valid;
  assign data_rd    = rd_en && reg_sel == SEL_DATA;

  fdc_cmd_collect u_collect (
    .clk(clk), .rst(rst), .flush(reset_edge), .byte_en(data_wr), .byte_in(wr_data),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .arg1(arg1), .arg2(arg2)
  );

  // command execution
  logic exec, is_seek, is_recal, is_sense, is_spec, is_known;
  logic [DRV_W-1:0]  tgt;
  logic [BYTE_W-1:0] seek_st0, recal_st0;
  logic unused_arg_bits;
  assign exec      = cmd_valid && !reset_edge;
  assign is_seek   = cmd_code == OP_SEEK;
  assign is_recal  = cmd_code == OP_RECAL;
  assign is_sense  = cmd_code == OP_SENSE;
  assign is_spec   = cmd_code == OP_SPECIFY;
  assign is_known  = is_seek || is_recal || is_sense || is_spec;
  assign tgt       = arg1[DRV_W-1:0];
  assign seek_st0  = {5'b0, arg1[2:0]} | ST0_SEEK_END;
  assign recal_st0 = {{(BYTE_W-DRV_W){1'b0}}, tgt} | ST0_SEEK_END;
  assign unused_arg_bits = ^arg1[BYTE_W-1:3];

  always_comb begin
    sense_hit = 1'b0;
    sense_idx = '0;
    for (int i = NUM_DRIVES - 1; i >= 0; i--) begin
      if (pend_v[i]) begin
        sense_hit = 1'b1;
        sense_idx = DRV_W'(i);
      end
    end
  end
  assign remaining = pend_v & ~(NUM_DRIVES'(1) << sense_idx);

  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drive
    fdc_drive_slot u_slot (
      .clk(clk), .rst(rst), .mark_all(reset_edge),
      .load(exec && (is_seek || is_recal) && tgt == DRV_W'(g)),
      .clear(exec && is_sense && sense_hit && sense_idx == DRV_W'(g)),
      .cyl_in(is_seek ? arg2 : '0),
      .st0_in(is_seek ? seek_st0 : recal_st0),
      .track(track_v[g]), .st0(st0_v[g]), .pend(pend_v[g])
    );
  end

  fdc_result_queue u_results (
    .clk(clk), .rst(rst), .flush(reset_edge),
    .push_two(exec && is_sense && sense_hit),
    .push_one(exec && ((is_sense && !sense_hit) || !is_known)),
    .in0((is_sense && sense_hit) ? st0_v[sense_idx] : RES_INVALID),
    .in1(track_v[sense_idx]),
    .pop(data_rd && res_avail),
    .head(res_head), .avail(res_avail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b1;
      irq_q  <= 1'b0;
      rd_q   <= '0;
      spec_q <= '0;
    end else begin
      if (dor_wr) hold_q <= !wr_data[CTRL_RUN_BIT];

      if (dor_wr && !wr_data[CTRL_RUN_BIT])                 irq_q <= 1'b0;
      else if (reset_edge)                                  irq_q <= 1'b1;
      else if (hold_q)                                      irq_q <= 1'b0;
      else if (exec && (is_seek || is_recal))               irq_q <= 1'b1;
      else if (exec && is_sense && sense_hit && remaining == '0) irq_q <= 1'b0;

      if (exec && is_spec) spec_q <= {arg1, arg2};

      if (rd_en) begin
        case (reg_sel)
          SEL_STAT: rd_q <= MSR_READY | (res_avail ? (MSR_TO_HOST | MSR_BUSY) : '0);
          SEL_DATA: rd_q <= res_avail ? res_head : RES_INVALID;
          default:  rd_q <= '1;
        endcase
      end
    end
  end

  assign rd_data     = rd_q;
  assign irq         = irq_q;
  assign spec_params = spec_q;

  // R2: held reset keeps the request line low
  a_r2_held_quiet: assert property (@(posedge clk) disable iff (rst)
    hold_q |-> !irq_q);
  // R6: the line is only high while some drive pends
  a_r6_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (pend_v != '0));
  // R4: a completed seek raises the line
  a_r4_seek_irq: assert property (@(posedge clk) disable iff (rst)
    (exec && is_seek && !hold_q && !dor_wr) |=> irq_q);
  // R7: the ready bit is always set in a status read
  a_r7_ready_bit: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_sel == SEL_STAT) |=> rd_data[7]);
endmodule

// File: tb/fdc_cmd_engine_test.sv
module fdc_cmd_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data;
  logic        irq;
  logic [15:0] spec_params;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fdc_cmd_engine uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .spec_params(spec_params)
  );

  localparam logic [2:0] KW = 3'd0, KR = 3'd1, KI = 3'd2, KSH = 3'd3, KSL = 3'd4;
  localparam logic [1:0] SC = 2'd0, SS = 2'd1, SD = 2'd2;
  localparam int NVEC = 100;
  // {requirement, kind, register, write byte, expected}
  localparam logic [24:0] VEC [NVEC] = '{
    {4'd3, KW, SC, 8'h0C, 8'h00},  // R3 leave held reset
    {4'd3, KI, SC, 8'h00, 8'h01},
    {4'd7, KR, SS, 8'h00, 8'h80},  // R7 idle status
    {4'd6, KW, SD, 8'h08, 8'h00},  // R6 drain drive 0
    {4'd7, KR, SS, 8'h00, 8'hD0},
    {4'd6, KR, SD, 8'h00, 8'hC0},
    {4'd6, KR, SD, 8'h00, 8'h00},
    {4'd7, KR, SS, 8'h00, 8'h80},
    {4'd6, KI, SC, 8'h00, 8'h01},
    {4'd6, KW, SD, 8'h08, 8'h00},  // drive 1
    {4'd6, KR, SD, 8'h00, 8'hC0},
    {4'd6, KR, SD, 8'h00, 8'h00},
    {4'd6, KW, SD, 8'h08, 8'h00},  // drive 2
    {4'd6, KR, SD, 8'h00, 8'hC0},
    {4'd6, KR, SD, 8'h00, 8'h00},
    {4'd6, KI, SC, 8'h00, 8'h01},
    {4'd6, KW, SD, 8'h08, 8'h00},  // drive 3, last
    {4'd6, KR, SD, 8'h00, 8'hC0},
    {4'd6, KR, SD, 8'h00, 8'h00},
    {4'd6, KI, SC, 8'h00, 8'h00},
    {4'd6, KW, SD, 8'h08, 8'h00},  // R6 nothing pending
    {4'd6, KR, SD, 8'h00, 8'h80},
    {4'd6, KR, SS, 8'h00, 8'h80},
    {4'd4, KW, SD, 8'h0F, 8'h00},  // R4 seek drive 2 head 1
    {4'd4, KW, SD, 8'h06, 8'h00},
    {4'd4, KW, SD, 8'h28, 8'h00},
    {4'd4, KI, SC, 8'h00, 8'h01},
    {4'd4, KW, SD, 8'h08, 8'h00},
    {4'd4, KR, SD, 8'h00, 8'h26},
    {4'd4, KR, SD, 8'h00, 8'h28},
    {4'd4, KI, SC, 8'h00, 8'h00},
    {4'd5, KW, SD, 8'h0F, 8'h00},  // R5 seek drive 3 then recalibrate
    {4'd5, KW, SD, 8'h03, 8'h00},
    {4'd5, KW, SD, 8'h40, 8'h00},
    {4'd5, KW, SD, 8'h07, 8'h00},
    {4'd5, KW, SD, 8'h03, 8'h00},
    {4'd5, KW, SD, 8'h08, 8'h00},
    {4'd5, KR, SD, 8'h00, 8'h23},
    {4'd5, KR, SD, 8'h00, 8'h00},
    {4'd5, KI, SC, 8'h00, 8'h00},
    {4'd6, KW, SD, 8'h0F, 8'h00},  // R6 drive 1 then drive 0 pending
    {4'd6, KW, SD, 8'h01, 8'h00},
    {4'd6, KW, SD, 8'h11, 8'h00},
    {4'd6, KW, SD, 8'h0F, 8'h00},
    {4'd6, KW, SD, 8'h00, 8'h00},
    {4'd6, KW, SD, 8'h33, 8'h00},
    {4'd6, KW, SD, 8'h08, 8'h00},
    {4'd6, KR, SD, 8'h00, 8'h20},
    {4'd6, KR, SD, 8'h00, 8'h33},
    {4'd6, KI, SC, 8'h00, 8'h01},
    {4'd6, KW, SD, 8'h08, 8'h00},
    {4'd6, KR, SD, 8'h00, 8'h21},
    {4'd6, KR, SD, 8'h00, 8'h11},
    {4'd6, KI, SC, 8'h00, 8'h00},
    {4'd9, KW, SD, 8'h06, 8'h00},  // R9 unrecognised code
    {4'd9, KR, SS, 8'h00, 8'hD0},
    {4'd9, KR, SD, 8'h00, 8'h80},
    {4'd9, KR, SS, 8'h00, 8'h80},
    {4'd9, KW, SD, 8'h4F, 8'h00},  // R9 seek with upper bits set
    {4'd9, KW, SD, 8'h00, 8'h00},
    {4'd9, KW, SD, 8'h05, 8'h00},
    {4'd9, KW, SD, 8'h08, 8'h00},
    {4'd9, KR, SD, 8'h00, 8'h20},
    {4'd9, KR, SD, 8'h00, 8'h05},
    {4'd8, KR, SD, 8'h00, 8'h80},  // R8 empty data read
    {4'd10, KW, SD, 8'h03, 8'h00}, // R10 specify
    {4'd10, KW, SD, 8'hAF, 8'h00},
    {4'd10, KW, SD, 8'h02, 8'h00},
    {4'd10, KR, SS, 8'h00, 8'h80},
    {4'd10, KSH, SC, 8'h00, 8'hAF},
    {4'd10, KSL, SC, 8'h00, 8'h02},
    {4'd11, KW, SD, 8'h08, 8'h00}, // R11 byte during result phase
    {4'd11, KW, SD, 8'h0F, 8'h00},
    {4'd11, KR, SD, 8'h00, 8'h80},
    {4'd11, KR, SS, 8'h00, 8'h80},
    {4'd11, KW, SD, 8'h07, 8'h00},
    {4'd11, KW, SD, 8'h01, 8'h00},
    {4'd11, KW, SD, 8'h08, 8'h00},
    {4'd11, KR, SD, 8'h00, 8'h21},
    {4'd11, KR, SD, 8'h00, 8'h00},
    {4'd2, KW, SD, 8'h0F, 8'h00},  // R2 seek drive 0, then hold
    {4'd2, KW, SD, 8'h00, 8'h00},
    {4'd2, KW, SD, 8'h44, 8'h00},
    {4'd2, KI, SC, 8'h00, 8'h01},
    {4'd2, KW, SC, 8'h08, 8'h00},
    {4'd2, KI, SC, 8'h00, 8'h00},
    {4'd2, KW, SD, 8'h08, 8'h00},
    {4'd2, KR, SS, 8'h00, 8'h80},
    {4'd3, KW, SC, 8'h0C, 8'h00},  // R3 release, partial command, reset again
    {4'd3, KW, SD, 8'h0F, 8'h00},
    {4'd3, KW, SC, 8'h08, 8'h00},
    {4'd3, KW, SC, 8'h0C, 8'h00},
    {4'd3, KW, SD, 8'h08, 8'h00},
    {4'd3, KR, SD, 8'h00, 8'hC0},
    {4'd3, KR, SD, 8'h00, 8'h44},
    {4'd3, KI, SC, 8'h00, 8'h01},
    {4'd3, KW, SD, 8'h08, 8'h00},  // R3 unread results discarded
    {4'd3, KW, SC, 8'h08, 8'h00},
    {4'd3, KW, SC, 8'h0C, 8'h00},
    {4'd3, KR, SS, 8'h00, 8'h80}
  };

  task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; reg_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(1, "irq after reset", {7'b0, irq}, 8'h00);
    check(1, "spec after reset", spec_params[7:0] | spec_params[15:8], 8'h00);
    bus_rd(SS, v);
    check(1, "status after reset", v, 8'h80);
    bus_rd(SD, v);
    check(1, "data read after reset", v, 8'h80);
    bus_wr(SD, 8'h07);  // R2 held: recalibrate ignored
    bus_wr(SD, 8'h00);
    check(2, "irq while held", {7'b0, irq}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      logic [24:0] e;
      e = VEC[i];
      case (e[20:18])
        KW:  bus_wr(e[17:16], e[15:8]);
        KR: begin
          bus_rd(e[17:16], v);
          check(int'(e[24:21]), $sformatf("vector %0d read", i), v, e[7:0]);
        end
        KI:  check(int'(e[24:21]), $sformatf("vector %0d irq", i), {7'b0, irq}, e[7:0]);
        KSH: check(int'(e[24:21]), $sformatf("vector %0d spec hi", i), spec_params[15:8], e[7:0]);
        default: check(int'(e[24:21]), $sformatf("vector %0d spec lo", i), spec_params[7:0], e[7:0]);
      endcase
    end

    // R1 synchronous reset returns to held state and clears results
    bus_wr(SD, 8'h08);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(1, "irq after second reset", {7'b0, irq}, 8'h00);
    bus_rd(SS, v);
    check(1, "status after second reset", v, 8'h80);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule